// File: doc/BRIEF.md
# Dual Complex Add/Subtract Accumulator

This block holds two independent 20-bit adder/subtractors, one serving the real part of a complex stream and one the imaginary part. Both see the same two 16-bit operand registers, loaded from ports A and B. Each has its own operation select and its own accumulator register. A shared feedback select swaps the A operand of both units for the unit's own accumulator, which turns the pair into accumulators for complex filters. A shared clear empties both accumulators. A shared delay select routes the real unit's A operand through an eight-stage deskew line. In FFT butterflies this re-phases data that did not pass through an external multiplier.

The operation select of each unit is an enumerated mode with four named values. OP_ADD (00) gives A+B. OP_AMB (01) gives A−B. OP_BMA (10) gives B−A. OP_PASS (11) passes A through. The per-cycle transition of each accumulator has three named cases. A reset goes to zero. A registered clear also goes to zero. Otherwise the accumulator loads the result of the selected mode. The 20-bit results and the overflow flags go on to a separate scaling stage.

Top module: `cxacc_pair`

## Requirements
- R1: Operand register A loads `a_in` on a rising edge when `a_load_n` is low and holds its value when `a_load_n` is high. Register B does the same with `b_in` and `b_load_n`.
- R2: Both 16-bit operands are sign-extended to 20 bits as two's complement. Each unit computes the mode set by its own 2-bit select, taken modulo 2^20: 00 gives A+B, 01 gives A−B, 10 gives B−A, 11 gives A.
- R3: Data, operation, feedback, clear and delay inputs presented before rising edge k produce their result on `res_re`/`res_im` right after edge k+1.
- R4: When the registered `fb_sel` is 1, each unit's A operand is its own accumulator value, so the result builds up cycle by cycle.
- R5: A registered `acc_clr` zeroes both accumulators and both overflow flags. This happens even when feedback is selected in the same cycle.
- R6: When the registered `dly_en` is 1, the real unit's A operand is the A register value from 8 cycles earlier. The imaginary unit still uses the current A register.
- R7: `ovf_re`/`ovf_im` are 1 exactly when the unit's 20-bit signed result overflowed in that cycle. They update together with the result, and OP_PASS never raises them.
- R8: While `rst_n` is low, the accumulators, the flags, the operand registers and the deskew line are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Operand A data, two's complement |
| b_in | input | 16 | Operand B data, same weighting as A |
| a_load_n | input | 1 | Active-low load enable of register A |
| b_load_n | input | 1 | Active-low load enable of register B |
| op_re | input | 2 | Mode select of the real unit |
| op_im | input | 2 | Mode select of the imaginary unit |
| fb_sel | input | 1 | 1 selects accumulator feedback as A operand |
| acc_clr | input | 1 | Clears both accumulators |
| dly_en | input | 1 | 1 routes real A operand through the deskew line |
| res_re | output | 20 | Real accumulator |
| res_im | output | 20 | Imaginary accumulator |
| ovf_re | output | 1 | Real overflow flag |
| ovf_im | output | 1 | Imaginary overflow flag |

## Verification
Every result appears two edges after its stimulus. The first edge captures operands and controls, and the second captures the accumulator. The bench therefore drives on a falling edge, lets two rising edges pass, and samples on the next falling edge. In the feedback runs, each further edge adds one more term, so a check is due after every edge. The deskew run compares each real result with the A value presented nine edges earlier: eight edges in the line plus the accumulator edge. The imaginary result is compared with the value presented one edge earlier.

// File: rtl/cxacc_pkg.sv
package cxacc_pkg;
    localparam int IN_W   = 16;
    localparam int ACC_W  = 20;
    localparam int DESKEW = 8;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_AMB  = 2'b01,
        OP_BMA  = 2'b10,
        OP_PASS = 2'b11
    } op_t;
endpackage

// File: rtl/cxacc_deskew.sv
module cxacc_deskew #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/cxacc_unit.sv
module cxacc_unit
    import cxacc_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_t          op,
    input  logic         fb,
    input  logic         clr,
    input  logic [W-1:0] a_new,
    input  logic [W-1:0] b_opd,
    output logic [W-1:0] acc,
    output logic         ovf
);
    logic [W-1:0] acc_q;
    logic         ovf_q;
    logic [W-1:0] opa;
    logic [W:0]   wide;

    // A operand mux: feedback or new data
    always_comb begin
        opa  = fb ? acc_q : a_new;
        wide = '0;
        unique case (op)
            OP_ADD:  wide = {opa[W-1], opa} + {b_opd[W-1], b_opd};
            OP_AMB:  wide = {opa[W-1], opa} - {b_opd[W-1], b_opd};
            OP_BMA:  wide = {b_opd[W-1], b_opd} - {opa[W-1], opa};
            OP_PASS: wide = {opa[W-1], opa};
        endcase
    end

    // Accumulator state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            acc_q <= wide[W-1:0];
            ovf_q <= wide[W] ^ wide[W-1];
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0 && !ovf_q));

    p_pass_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS && !clr) |=> (acc_q == $past(opa)));

    p_pass_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS && !clr) |=> !ovf_q);

    p_feedback_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb && !clr && op == OP_ADD) |=> (acc_q == W'($past(acc_q) + $past(b_opd))));
endmodule

// File: rtl/cxacc_pair.sv
module cxacc_pair
    import cxacc_pkg::*;
#(
    parameter int IW    = cxacc_pkg::IN_W,
    parameter int AW    = cxacc_pkg::ACC_W,
    parameter int DEPTH = cxacc_pkg::DESKEW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] a_in,
    input  logic [IW-1:0] b_in,
    input  logic          a_load_n,
    input  logic          b_load_n,
    input  logic [1:0]    op_re,
    input  logic [1:0]    op_im,
    input  logic          fb_sel,
    input  logic          acc_clr,
    input  logic          dly_en,
    output logic [AW-1:0] res_re,
    output logic [AW-1:0] res_im,
    output logic          ovf_re,
    output logic          ovf_im
);
    localparam int EXT = AW - IW;

    logic [IW-1:0] a_q, b_q, a_late;
    op_t           op_re_q, op_im_q;
    logic          fb_q, clr_q, dly_q;
    logic [AW-1:0] a_re_ext, a_im_ext, b_ext;

    // Operand registers with active-low load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (!a_load_n) a_q <= a_in;
            if (!b_load_n) b_q <= b_in;
        end
    end

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_re_q <= OP_ADD;
            op_im_q <= OP_ADD;
            fb_q    <= 1'b0;
            clr_q   <= 1'b0;
            dly_q   <= 1'b0;
        end else begin
            op_re_q <= op_t'(op_re);
            op_im_q <= op_t'(op_im);
            fb_q    <= fb_sel;
            clr_q   <= acc_clr;
            dly_q   <= dly_en;
        end
    end

    cxacc_deskew #(.W(IW), .DEPTH(DEPTH)) i_deskew (
        .clk (clk),
        .rst_n (rst_n),
        .din (a_q),
        .dout (a_late)
    );

    always_comb begin
        a_re_ext = dly_q ? {{EXT{a_late[IW-1]}}, a_late} : {{EXT{a_q[IW-1]}}, a_q};
        a_im_ext = {{EXT{a_q[IW-1]}}, a_q};
        b_ext    = {{EXT{b_q[IW-1]}}, b_q};
    end

    cxacc_unit #(.W(AW)) i_unit_re (
        .clk (clk), .rst_n (rst_n), .op (op_re_q), .fb (fb_q), .clr (clr_q),
        .a_new (a_re_ext), .b_opd (b_ext), .acc (res_re), .ovf (ovf_re)
    );

    cxacc_unit #(.W(AW)) i_unit_im (
        .clk (clk), .rst_n (rst_n), .op (op_im_q), .fb (fb_q), .clr (clr_q),
        .a_new (a_im_ext), .b_opd (b_ext), .acc (res_im), .ovf (ovf_im)
    );

    p_a_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        a_load_n |=> (a_q == $past(a_q)));

    p_b_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        b_load_n |=> (b_q == $past(b_q)));
endmodule

// File: tb/test_cxacc_pair.sv
module test_cxacc_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic        a_load_n = 1'b1, b_load_n = 1'b1;
    logic [1:0]  op_re = 2'b00, op_im = 2'b00;
    logic        fb_sel = 1'b0, acc_clr = 1'b0, dly_en = 1'b0;
    logic [19:0] res_re, res_im;
    logic        ovf_re, ovf_im;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cxacc_pair i_cxacc_pair (
        .clk, .rst_n, .a_in, .b_in, .a_load_n, .b_load_n, .op_re, .op_im,
        .fb_sel, .acc_clr, .dly_en, .res_re, .res_im, .ovf_re, .ovf_im
    );

    // {a, b, op_re, op_im, exp_re, exp_im}
    localparam logic [75:0] VEC [8] = '{
        {16'h0005, 16'h0003, 2'b00, 2'b01, 20'h00008, 20'h00002},
        {16'h0005, 16'h0003, 2'b10, 2'b11, 20'hFFFFE, 20'h00005},
        {16'h8000, 16'h8000, 2'b00, 2'b01, 20'hF0000, 20'h00000},
        {16'h7FFF, 16'h8000, 2'b01, 2'b10, 20'h0FFFF, 20'hF0001},
        {16'hFFFF, 16'h0001, 2'b00, 2'b11, 20'h00000, 20'hFFFFF},
        {16'h1234, 16'h0F0F, 2'b00, 2'b10, 20'h02143, 20'hFFCDB},
        {16'h7FFF, 16'h7FFF, 2'b00, 2'b01, 20'h0FFFE, 20'h00000},
        {16'hC000, 16'h4000, 2'b10, 2'b00, 20'h08000, 20'h00000}
    };

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edge2();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R8 reset state
        #5;
        chk("R8 reset res_re", res_re, 20'h0);
        chk("R8 reset res_im", res_im, 20'h0);
        chk("R8 reset ovf", {18'h0, ovf_re, ovf_im}, 20'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R2/R3 table of modes, each due two edges after drive
        foreach (VEC[i]) begin
            a_in = VEC[i][75:60]; b_in = VEC[i][59:44];
            op_re = VEC[i][43:42]; op_im = VEC[i][41:40];
            a_load_n = 1'b0; b_load_n = 1'b0;
            fb_sel = 1'b0; acc_clr = 1'b0; dly_en = 1'b0;
            edge2(); edge2();
            chk($sformatf("R2 R3 vec%0d res_re", i), res_re, VEC[i][39:20]);
            chk($sformatf("R2 vec%0d res_im", i), res_im, VEC[i][19:0]);
            chk($sformatf("R7 vec%0d ovf", i), {18'h0, ovf_re, ovf_im}, 20'h0);
        end

        // R1 load enables high hold operand registers
        a_in = 16'h0100; b_in = 16'h0010; a_load_n = 1'b0; b_load_n = 1'b0;
        op_re = 2'b11; op_im = 2'b00;
        edge2();
        a_in = 16'h7777; b_in = 16'h5555; a_load_n = 1'b1; b_load_n = 1'b1;
        edge2(); edge2();
        chk("R1 A held", res_re, 20'h00100);
        chk("R1 B held", res_im, 20'h00110);

        // R6 deskew: real sees A from 9 drives back, imag from 1 back
        a_load_n = 1'b0; dly_en = 1'b1; op_re = 2'b11; op_im = 2'b11;
        for (int k = 0; k < 12; k++) begin
            a_in = 16'h0100 + 16'(k * 16'h0011);
            edge2();
            if (k >= 9) begin
                chk($sformatf("R6 delayed k%0d", k), res_re, {4'h0, 16'h0100 + 16'((k - 9) * 16'h0011)});
                chk($sformatf("R6 undelayed imag k%0d", k), res_im, {4'h0, 16'h0100 + 16'((k - 1) * 16'h0011)});
            end
        end
        dly_en = 1'b0;

        // R5 clear wins over feedback, then R4/R7 accumulation to overflow
        op_re = 2'b00; op_im = 2'b01; fb_sel = 1'b1; acc_clr = 1'b1;
        b_in = 16'h7FFF; b_load_n = 1'b0; a_load_n = 1'b1;
        edge2();
        acc_clr = 1'b0;
        edge2();
        chk("R5 clear wins re", res_re, 20'h0);
        chk("R5 clear wins im", res_im, 20'h0);
        for (int n = 1; n <= 17; n++) begin
            edge2();
            chk($sformatf("R4 acc re n%0d", n), res_re, 20'(n * 32767));
            chk($sformatf("R4 acc im n%0d", n), res_im, 20'(-n * 32767));
            if (n >= 16) begin
                chk($sformatf("R7 ovf re n%0d", n), {19'h0, ovf_re}, {19'h0, n == 17});
                chk($sformatf("R7 ovf im n%0d", n), {19'h0, ovf_im}, {19'h0, n == 17});
            end
        end

        // R5 clear drops flags and both accumulators
        acc_clr = 1'b1; fb_sel = 1'b0;
        edge2();
        acc_clr = 1'b0;
        edge2();
        chk("R5 clear re", res_re, 20'h0);
        chk("R5 clear im", res_im, 20'h0);
        chk("R5 clear ovf", {18'h0, ovf_re, ovf_im}, 20'h0);

        // R8 reset mid-run
        a_in = 16'h1111; a_load_n = 1'b0; op_re = 2'b11; op_im = 2'b11;
        edge2(); edge2();
        chk("R8 pre-reset value", res_re, 20'h01111);
        rst_n = 1'b0;
        #2;
        chk("R8 reset re", res_re, 20'h0);
        chk("R8 reset im", res_im, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule